// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer with Result Buffer

This block is used when a dual converter samples its inputs in pseudo-differential mode and picks the channels automatically. A single convert-start pulse runs a programmed channel list for a programmed number of conversions. For each step the block drives the input multiplexer select. It then captures the simultaneous result pair (lane A and lane B) when the converter core signals that the step is done.

The channel list always counts down. With a length code L, each conversion covers channels L, L-1, ..., 0. With a depth code D, the list is repeated for D+1 conversions, so (L+1)(D+1) result pairs are stored in capture order.

A single read strobe streams every stored pair to the serial output stage, one pair per clock, in the same order: conversion 1 from channel L down to 0, then conversion 2, and so on. The multiplexer select also serves as the read-only sequence-position field.

Top module: `conv_seq_fifo`

## Requirements
- R1: After reset, `mux_sel` is 0, `out_valid` is 0, and `out_a` and `out_b` are 0.
- R2: A `conv_start` seen while idle begins a sequence. From the next cycle `mux_sel` equals the length code L. Each accepted `conv_done` moves it to the next channel down, and it wraps from 0 back to L for the next conversion.
- R3: During a sequence, each `conv_done` stores the pair (`res_a`, `res_b`). After (L+1)(D+1) stores the sequence ends and `mux_sel` returns to L.
- R4: A `rd_strobe` seen while no stream runs starts a stream. `out_valid` is high on exactly (L+1)(D+1) consecutive cycles, beginning one cycle after the strobe. The beats carry the stored pairs in capture order.
- R5: The length and depth codes are taken when the sequence starts. Changing them while the sequence runs does not alter the channel order or the result count.
- R6: A `conv_start` that arrives while a sequence is running is ignored.
- R7: A `conv_done` that arrives while no sequence is running is ignored, and the stored results are unchanged.
- R8: Starting a new sequence discards all earlier results. A read issued before any new result arrives returns only zero words.
- R9: A read issued before the sequence completes returns the pairs already stored, followed by zero words for the positions not yet converted.
- R10: A `rd_strobe` during a running stream is ignored. The stream neither restarts nor lengthens.
- R11: Outside a stream, `out_valid`, `out_a` and `out_b` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_len_code | input | SEL_W | Channel-list length code L (L+1 channels, counted from L down to 0) |
| depth_code | input | DEPTH_W | Conversion-count code D (D+1 conversions per sequence) |
| conv_start | input | 1 | Single-cycle pulse starting a sequence |
| conv_done | input | 1 | Converter core finished the current step; results valid |
| res_a | input | DATA_W | Lane A result for the current step |
| res_b | input | DATA_W | Lane B result for the current step |
| rd_strobe | input | 1 | Single-cycle pulse requesting read-out of all results |
| mux_sel | output | SEL_W | Input multiplexer select; also the sequence-position field |
| out_valid | output | 1 | A result pair is presented this cycle |
| out_a | output | DATA_W | Lane A word of the current beat |
| out_b | output | DATA_W | Lane B word of the current beat |

## Verification
The bench targets the following boundaries:
- **Single-channel list.** With L equal to 0 the select must stay at 0. A design that decrements without wrapping would walk into a channel that does not exist.
- **Full-size sequence.** The 16-entry case shows whether the write pointer or the beat counter overflows, or whether the last pair is dropped.
- **Partial reads.** Reads issued mid-sequence and right after a restart expose a buffer that keeps stale pairs from the previous sequence, or one that emits garbage instead of zeros.
- **Control interference.** A second start, a late code change, a stray conv_done while idle and a second strobe mid-stream each reveal a design that restarts, re-counts or overwrites data it should have left alone.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic {
        RD_IDLE   = 1'b0,
        RD_STREAM = 1'b1
    } rd_state_e;

endpackage

// File: rtl/cseq_ctrl.sv
module cseq_ctrl #(
    parameter int SEL_W   = 2,
    parameter int DEPTH_W = 2,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   len_code,
    input  logic [DEPTH_W-1:0] depth_code,
    input  logic               start,
    input  logic               done,
    output logic               busy,
    output logic [SEL_W-1:0]   mux_sel,
    output logic               wr_en,
    output logic [CNT_W-1:0]   wr_cnt,
    output logic [CNT_W-1:0]   total
);
    import cseq_pkg::*;

    typedef struct packed {
        seq_state_e       state;
        logic [SEL_W-1:0] mux;
        logic [SEL_W-1:0] last;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] total;
    } ctrl_t;

    ctrl_t q, d;
    logic [CNT_W-1:0] ch_n, cv_n;

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        ch_n  = CNT_W'(len_code) + CNT_W'(1);
        cv_n  = CNT_W'(depth_code) + CNT_W'(1);
        if (q.state == SEQ_IDLE) begin
            if (start) begin
                d.state = SEQ_RUN;
                d.mux   = len_code;
                d.last  = len_code;
                d.cnt   = '0;
                d.total = ch_n * cv_n;
            end
        end else if (done) begin
            wr_en = 1'b1;
            d.cnt = q.cnt + CNT_W'(1);
            if (d.cnt == q.total) begin
                d.state = SEQ_IDLE;
                d.mux   = q.last;
            end else if (q.mux == '0) begin
                d.mux = q.last;
            end else begin
                d.mux = q.mux - SEL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= SEQ_IDLE;
            q.mux   <= '0;
            q.last  <= '0;
            q.cnt   <= '0;
            q.total <= CNT_W'(1);
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.state == SEQ_RUN);
    assign mux_sel = q.mux;
    assign wr_cnt  = q.cnt;
    assign total   = q.total;

    // R3: never store beyond the programmed count
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (q.cnt < q.total));

    // R2: select stays within the latched channel list
    a_r2_mux_in_list: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.mux <= q.last));

    // R3: the final store ends the sequence and restores the first channel
    a_r3_end_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done && (q.cnt + CNT_W'(1) == q.total)) |=> (!busy && mux_sel == $past(q.last)));

    // R6: a start during a sequence leaves the sequence untouched
    a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> ($stable(mux_sel) && $stable(total) && $stable(wr_cnt)));

    // R7: a done while idle stores nothing
    a_r7_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && done) |=> (!busy && $stable(wr_cnt)));

endmodule

// File: rtl/cseq_store.sv
module cseq_store #(
    parameter int DATA_W = 16,
    parameter int SLOTS  = 16,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 5
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [2*DATA_W-1:0] wr_data,
    input  logic                rd_en,
    input  logic [CNT_W-1:0]    rd_idx,
    input  logic [CNT_W-1:0]    valid_cnt,
    output logic [2*DATA_W-1:0] rd_data
);
    logic [2*DATA_W-1:0] mem [SLOTS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        if (rd_en && (rd_idx < valid_cnt)) begin
            rd_data = mem[rd_idx[ADDR_W-1:0]];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/cseq_reader.sv
module cseq_reader #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [CNT_W-1:0] total,
    output logic             active,
    output logic [CNT_W-1:0] idx
);
    import cseq_pkg::*;

    typedef struct packed {
        rd_state_e        state;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] len;
    } rd_t;

    rd_t q, d;

    always_comb begin
        d = q;
        if (q.state == RD_IDLE) begin
            if (strobe) begin
                d.state = RD_STREAM;
                d.idx   = '0;
                d.len   = total;
            end
        end else if (q.idx + CNT_W'(1) == q.len) begin
            d.state = RD_IDLE;
            d.idx   = '0;
        end else begin
            d.idx = q.idx + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= RD_IDLE;
            q.idx   <= '0;
            q.len   <= CNT_W'(1);
        end else begin
            q <= d;
        end
    end

    assign active = (q.state == RD_STREAM);
    assign idx    = q.idx;

    // R4: a strobe while idle opens a stream at the first entry
    a_r4_stream_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && strobe) |=> (active && idx == '0));

    // R4: the beat index stays below the latched length
    a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx < q.len));

    // R10: a strobe mid-stream only advances the stream
    a_r10_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (active && strobe && (idx + CNT_W'(1) != q.len)) |=> (active && idx == $past(idx) + CNT_W'(1)));

endmodule

// File: rtl/conv_seq_fifo.sv
module conv_seq_fifo #(
    parameter int DATA_W  = 16,
    parameter int SEL_W   = 2,
    parameter int DEPTH_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   seq_len_code,
    input  logic [DEPTH_W-1:0] depth_code,
    input  logic               conv_start,
    input  logic               conv_done,
    input  logic [DATA_W-1:0]  res_a,
    input  logic [DATA_W-1:0]  res_b,
    input  logic               rd_strobe,
    output logic [SEL_W-1:0]   mux_sel,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_a,
    output logic [DATA_W-1:0]  out_b
);
    localparam int MAX_CH = 1 << SEL_W;
    localparam int MAX_CV = 1 << DEPTH_W;
    localparam int SLOTS  = MAX_CH * MAX_CV;
    localparam int ADDR_W = $clog2(SLOTS);
    localparam int CNT_W  = $clog2(SLOTS + 1);

    logic               busy;
    logic               wr_en;
    logic [CNT_W-1:0]   wr_cnt;
    logic [CNT_W-1:0]   total;
    logic               rd_active;
    logic [CNT_W-1:0]   rd_idx;
    logic [2*DATA_W-1:0] rd_data;

    cseq_ctrl #(
        .SEL_W   (SEL_W),
        .DEPTH_W (DEPTH_W),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_code   (seq_len_code),
        .depth_code (depth_code),
        .start      (conv_start),
        .done       (conv_done),
        .busy       (busy),
        .mux_sel    (mux_sel),
        .wr_en      (wr_en),
        .wr_cnt     (wr_cnt),
        .total      (total)
    );

    cseq_store #(
        .DATA_W (DATA_W),
        .SLOTS  (SLOTS),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_store (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_cnt[ADDR_W-1:0]),
        .wr_data   ({res_a, res_b}),
        .rd_en     (rd_active),
        .rd_idx    (rd_idx),
        .valid_cnt (wr_cnt),
        .rd_data   (rd_data)
    );

    cseq_reader #(
        .CNT_W (CNT_W)
    ) u_reader (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (rd_strobe),
        .total  (total),
        .active (rd_active),
        .idx    (rd_idx)
    );

    assign out_valid      = rd_active;
    assign {out_a, out_b} = rd_data;

    // R11: the output words are quiet outside a stream
    a_r11_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_a == '0 && out_b == '0));

    // R8: a fresh sequence holds no results yet
    a_r8_fresh_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && conv_start) |=> (wr_cnt == '0));

endmodule

// File: tb/conv_seq_fifo_tb.sv
`timescale 1ns/1ps
module conv_seq_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  seq_len_code = '0;
    logic [1:0]  depth_code = '0;
    logic        conv_start = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] res_a = '0;
    logic [15:0] res_b = '0;
    logic        rd_strobe = 1'b0;
    logic [1:0]  mux_sel;
    logic        out_valid;
    logic [15:0] out_a;
    logic [15:0] out_b;

    always #2.5 clk = ~clk;

    conv_seq_fifo u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .seq_len_code (seq_len_code),
        .depth_code   (depth_code),
        .conv_start   (conv_start),
        .conv_done    (conv_done),
        .res_a        (res_a),
        .res_b        (res_b),
        .rd_strobe    (rd_strobe),
        .mux_sel      (mux_sel),
        .out_valid    (out_valid),
        .out_a        (out_a),
        .out_b        (out_b)
    );

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] word;
        string       tag;
    } beat_t;
    beat_t exp_q[$];

    logic [31:0] mdl [16];
    int  m_cnt = 0;
    int  m_total = 1;
    int  m_last = 0;
    int  m_mux = 0;
    bit  m_busy = 0;
    int  seed_k = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every presented beat
    always @(negedge clk) begin
        beat_t e;
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected beat", {out_a, out_b}, 32'h0);
            end else begin
                e = exp_q.pop_front();
                chk({out_a, out_b} == e.word, e.tag, {out_a, out_b}, e.word);
            end
        end
    end

    task automatic start_seq(input int l, input int dd, input string tag);
        @(negedge clk);
        seq_len_code = 2'(l);
        depth_code   = 2'(dd);
        conv_start   = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        if (!m_busy) begin
            m_busy  = 1;
            m_cnt   = 0;
            m_total = (l + 1) * (dd + 1);
            m_last  = l;
            m_mux   = l;
        end
        chk(int'(mux_sel) == m_mux, tag, 32'(mux_sel), 32'(m_mux));
    endtask

    task automatic convert(input string tag);
        logic [15:0] a, b;
        seed_k++;
        a = 16'hA000 + 16'(seed_k * 7);
        b = 16'h5000 ^ 16'(seed_k * 13);
        @(negedge clk);
        chk(int'(mux_sel) == m_mux, tag, 32'(mux_sel), 32'(m_mux));
        res_a = a;
        res_b = b;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        if (m_busy) begin
            mdl[m_cnt] = {a, b};
            m_cnt++;
            if (m_cnt == m_total) begin
                m_busy = 0;
                m_mux  = m_last;
            end else if (m_mux == 0) begin
                m_mux = m_last;
            end else begin
                m_mux = m_mux - 1;
            end
        end
    endtask

    task automatic read_all(input string tag, input int second);
        beat_t e;
        @(negedge clk);
        rd_strobe = 1'b1;
        for (int i = 0; i < m_total; i++) begin
            e.word = (i < m_cnt) ? mdl[i] : 32'h0;
            e.tag  = tag;
            exp_q.push_back(e);
        end
        @(negedge clk);
        rd_strobe = 1'b0;
        if (second > 0) begin
            repeat (second) @(negedge clk);
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
        end
        repeat (m_total + 1) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " beat count"}, 32'(exp_q.size()), 32'h0);
        chk(!out_valid && out_a == 16'h0 && out_b == 16'h0, "R11 quiet after stream",
            {15'h0, out_valid, out_a}, 32'h0);
        exp_q.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(mux_sel == 2'd0, "R1 mux_sel", 32'(mux_sel), 32'h0);
        chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'h0);
        chk(out_a == 16'h0 && out_b == 16'h0, "R1 words", {out_a, out_b}, 32'h0);
        rst_n = 1'b1;

        // Single-channel list, two conversions
        start_seq(0, 1, "R2 start L0");
        for (int i = 0; i < 2; i++) convert("R2 L0 select");
        chk(int'(mux_sel) == 0, "R3 end L0", 32'(mux_sel), 32'h0);
        read_all("R4 L0D1", 0);

        // Three channels, two conversions
        start_seq(2, 1, "R2 start L2");
        for (int i = 0; i < 6; i++) convert("R2 L2 select");
        chk(int'(mux_sel) == 2, "R3 end L2", 32'(mux_sel), 32'h2);
        read_all("R4 L2D1", 0);

        // Full-size sequence
        start_seq(3, 3, "R2 start L3");
        for (int i = 0; i < 16; i++) convert("R2 L3 select");
        chk(int'(mux_sel) == 3, "R3 end L3", 32'(mux_sel), 32'h3);
        read_all("R3 R4 L3D3", 0);

        // R6: start during a running sequence
        start_seq(2, 0, "R2 start L2D0");
        convert("R6 before");
        start_seq(0, 3, "R6 second start ignored");
        for (int i = 0; i < 2; i++) convert("R6 select");
        chk(int'(mux_sel) == 2, "R6 end", 32'(mux_sel), 32'h2);
        read_all("R6 data", 0);

        // R7: done while idle
        convert("R7 idle done");
        read_all("R7 data unchanged", 0);

        // R5: codes changed mid-sequence
        start_seq(2, 1, "R5 start");
        convert("R5 select");
        @(negedge clk);
        seq_len_code = 2'd0;
        depth_code   = 2'd0;
        for (int i = 0; i < 5; i++) convert("R5 select latched");
        read_all("R5 data", 0);

        // R8: read right after a restart
        start_seq(1, 1, "R8 start");
        read_all("R8 zeros", 0);
        // R9: read after partial progress
        for (int i = 0; i < 2; i++) convert("R9 select");
        read_all("R9 partial", 0);
        for (int i = 0; i < 2; i++) convert("R9 select tail");
        read_all("R4 L1D1", 0);

        // R10: second strobe in the middle of a stream
        read_all("R10 restrobe", 1);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule